// File: doc/BRIEF.md
# Multiplexed Strobe Bus Slave

This block is the fabric-side slave for a host that has no bus of its own and instead drives a shared 32-bit address/data bus from general-purpose pins, plus two control lines: a start strobe and a write-select line (1 = write, 0 = read or data). Nothing is clocked by the host. Every host line passes through a synchronizer chain into the local clock, and the slave watches the synchronized start line for its edges. A rising edge opens a phase, and the falling edge captures the word on the bus.

A write is two phases. First comes an address phase with start high and write-select high. Then comes a data phase with start high and write-select low. When the data phase closes, a single-cycle write strobe goes to an internal register port, together with the captured address and data. A read is one address phase with write-select low. The slave then strobes a read enable to the register port, samples the returned word one cycle later, and drives it onto the bus with output enable high. It holds the word there until the host opens the next phase. If the host opens that phase before the word has reached the bus, the read is abandoned and a sticky overrun flag is set.

The phase state machine has these states: IDLE, WR_ADDR (write address phase open), WR_WAIT (address held, waiting for data), WR_DATA (data phase open), RD_ADDR (read address phase open), RD_REQ (read enable asserted), RD_LOAD (register port answer being sampled) and RD_HOLD (word driven onto the bus). The transitions are:
- IDLE and RD_HOLD go to WR_ADDR or RD_ADDR on a start rise, chosen by write-select.
- WR_ADDR goes to WR_WAIT on a start fall.
- WR_WAIT goes to WR_DATA on a rise with write-select low, or back to WR_ADDR on a rise with write-select high.
- WR_DATA goes to IDLE on a fall.
- RD_ADDR goes to RD_REQ on a fall.
- RD_REQ goes to RD_LOAD, and RD_LOAD goes to RD_HOLD, unless a rise arrives first. In that case the overrun is flagged and the machine goes straight to WR_ADDR or RD_ADDR.

Top module: `strobe_bus_slave`

## Requirements
- R1: A write address phase (start high, write-select 1) followed by a data phase (start high, write-select 0) produces exactly one reg_we pulse, with reg_addr equal to the address word and reg_wdata equal to the data word.
- R2: The bus word of a phase is captured at the synchronized falling edge of start. A bus value that changes while start is high is taken at its last value before start falls.
- R3: A read address phase (write-select 0) that starts from idle or from a held read produces exactly one reg_re pulse, with reg_addr equal to the address word. reg_rdata is sampled in the cycle after reg_re.
- R4: After a read, bus_oe is 1 and bus_out equals the sampled word. Both are held unchanged until the next synchronized start rise, at which point bus_oe returns to 0.
- R5: bus_oe is 0 in every state except the read hold. It is never 1 during idle or during any write phase.
- R6: A start rise with write-select 1 while the slave is waiting for write data starts a new address phase. The earlier address is discarded, and no reg_we is issued for it.
- R7: A start rise within the two cycles after a read address phase closes, before the word reaches the bus, sets overrun. That read never asserts bus_oe, and the rise opens a new phase. overrun stays set until reset.
- R8: reg_we and reg_re are each high for at most one consecutive cycle and are never high together.
- R9: A synchronous reset returns the machine to idle, clears overrun, deasserts bus_oe, and leaves reg_we and reg_re low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_in | input | 32 | Host-driven address/data bus (asynchronous) |
| start_in | input | 1 | Host start strobe (asynchronous) |
| wr_sel_in | input | 1 | Host write select: 1 write address, 0 read address or write data |
| bus_out | output | 32 | Read word returned to the host |
| bus_oe | output | 1 | Output enable for the bus buffers |
| reg_addr | output | 32 | Register port address |
| reg_wdata | output | 32 | Register port write data |
| reg_we | output | 1 | Register port write strobe, one cycle |
| reg_re | output | 1 | Register port read enable, one cycle |
| reg_rdata | input | 32 | Register port read data, valid the cycle after reg_re |
| overrun | output | 1 | Sticky flag: a read word was not delivered in time |

## Verification
The properties assume the host keeps the bus and write-select stable from before each start rise until at least three clocks after start falls. They also assume each start level, high or low, lasts at least one clock, so that every edge survives the synchronizer. The bench drives all host lines on falling clock edges and holds each phase for several cycles, with one exception. That exception is the overrun scenario, which deliberately reopens start a single cycle after clearing it. The register port model answers combinationally from reg_addr, so the word sampled in the cycle after reg_re is always defined.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Phase state machine encoding
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_ADDR,
        ST_WR_WAIT,
        ST_WR_DATA,
        ST_RD_ADDR,
        ST_RD_REQ,
        ST_RD_LOAD,
        ST_RD_HOLD
    } sbs_state_e;

    localparam int unsigned SBS_BUS_W       = 32;
    localparam int unsigned SBS_SYNC_STAGES = 2;

endpackage

// File: rtl/sbs_sync.sv
module sbs_sync #(
    parameter int unsigned W      = 34,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int unsigned LAST = STAGES - 1;

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign dout = stg[LAST];

endmodule

// File: rtl/sbs_edge.sv
module sbs_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;

endmodule

// File: rtl/sbs_fsm.sv
module sbs_fsm
    import sbs_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fall,
    input  logic          s_wr,
    input  logic [DW-1:0] s_bus,
    input  logic [DW-1:0] reg_rdata,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          overrun
);

    sbs_state_e state, state_n;
    sbs_state_e open_tgt;

    logic [DW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] hold_q;
    logic          we_q;
    logic          ovr_q;

    // Phase to enter on a start rise, picked by write-select
    assign open_tgt = s_wr ? ST_WR_ADDR : ST_RD_ADDR;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_n;
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (rise) state_n = open_tgt;
            ST_WR_ADDR: if (fall) state_n = ST_WR_WAIT;
            ST_WR_WAIT: if (rise) state_n = s_wr ? ST_WR_ADDR : ST_WR_DATA;
            ST_WR_DATA: if (fall) state_n = ST_IDLE;
            ST_RD_ADDR: if (fall) state_n = ST_RD_REQ;
            ST_RD_REQ:  state_n = rise ? open_tgt : ST_RD_LOAD;
            ST_RD_LOAD: state_n = rise ? open_tgt : ST_RD_HOLD;
            ST_RD_HOLD: if (rise) state_n = open_tgt;
            default:    state_n = ST_IDLE;
        endcase
    end

    // Output and datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            hold_q  <= '0;
            we_q    <= 1'b0;
            ovr_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            unique case (state)
                ST_WR_ADDR, ST_RD_ADDR: begin
                    if (fall) addr_q <= s_bus;
                end
                ST_WR_DATA: begin
                    if (fall) begin
                        wdata_q <= s_bus;
                        we_q    <= 1'b1;
                    end
                end
                ST_RD_REQ: begin
                    if (rise) ovr_q <= 1'b1;
                end
                ST_RD_LOAD: begin
                    if (rise) ovr_q  <= 1'b1;
                    else      hold_q <= reg_rdata;
                end
                default: ;
            endcase
        end
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;
    assign reg_re    = (state == ST_RD_REQ);
    assign bus_oe    = (state == ST_RD_HOLD);
    assign bus_out   = bus_oe ? hold_q : '0;
    assign overrun   = ovr_q;

endmodule

// File: rtl/strobe_bus_slave.sv
module strobe_bus_slave
    import sbs_pkg::*;
#(
    parameter int unsigned DW          = SBS_BUS_W,
    parameter int unsigned SYNC_STAGES = SBS_SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] bus_in,
    input  logic          start_in,
    input  logic          wr_sel_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    output logic          reg_re,
    input  logic [DW-1:0] reg_rdata,
    output logic          overrun
);

    localparam int unsigned SW = DW + 2;

    logic [SW-1:0] raw_v, syn_v;
    logic [DW-1:0] s_bus;
    logic          s_start, s_wr;
    logic          rise, fall;

    assign raw_v = {start_in, wr_sel_in, bus_in};
    assign {s_start, s_wr, s_bus} = syn_v;

    sbs_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_v),
        .dout (syn_v)
    );

    sbs_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (s_start),
        .rise  (rise),
        .fall  (fall)
    );

    sbs_fsm #(.DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .rise      (rise),
        .fall      (fall),
        .s_wr      (s_wr),
        .s_bus     (s_bus),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .overrun   (overrun)
    );

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic          reg_re,
    input logic          bus_oe,
    input logic [DW-1:0] bus_out,
    input logic          overrun
);

    p_we_single_r8: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    p_re_single_r8: assert property (@(posedge clk) disable iff (rst)
        reg_re |=> !reg_re);

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_re));

    p_oe_after_re_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(reg_re, 2));

    p_oe_word_held_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

    p_no_oe_on_write_r5: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> !bus_oe);

    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind strobe_bus_slave sbs_checker #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .bus_oe  (bus_oe),
    .bus_out (bus_out),
    .overrun (overrun)
);

// File: tb/strobe_bus_slave_tb_top.sv
module strobe_bus_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RD_KEY = 32'h5A5A_F00F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_in = '0;
    logic        start_in = 1'b0;
    logic        wr_sel_in = 1'b0;
    logic [31:0] bus_out, reg_addr, reg_wdata, reg_rdata;
    logic        bus_oe, reg_we, reg_re, overrun;

    int n_cmp = 0;
    int n_bad = 0;
    int we_cnt = 0, re_cnt = 0;
    int we_run = 0, re_run = 0, max_we_run = 0, max_re_run = 0, both_cnt = 0;
    int oe_in_write = 0;
    bit in_write = 1'b0;
    logic [31:0] last_waddr = '0, last_wdata = '0, last_raddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Register port model: answers from the address
    assign reg_rdata = reg_addr ^ RD_KEY;

    strobe_bus_slave dut_i (
        .clk(clk), .rst(rst), .bus_in(bus_in), .start_in(start_in),
        .wr_sel_in(wr_sel_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata), .overrun(overrun)
    );

    // Port monitor
    always @(posedge clk) begin
        if (!rst) begin
            if (reg_we) begin
                we_cnt <= we_cnt + 1; last_waddr <= reg_addr; last_wdata <= reg_wdata;
            end
            if (reg_re) begin
                re_cnt <= re_cnt + 1; last_raddr <= reg_addr;
            end
            we_run <= reg_we ? we_run + 1 : 0;
            re_run <= reg_re ? re_run + 1 : 0;
            if (we_run + 1 > max_we_run && reg_we) max_we_run <= we_run + 1;
            if (re_run + 1 > max_re_run && reg_re) max_re_run <= re_run + 1;
            if (reg_we && reg_re) both_cnt <= both_cnt + 1;
            if (in_write && bus_oe) oe_in_write <= oe_in_write + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic phase(input logic [31:0] w, input logic wr);
        @(negedge clk); bus_in = w; wr_sel_in = wr;
        @(negedge clk); start_in = 1'b1;
        repeat (4) @(negedge clk);
        start_in = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R9 oe", {31'd0, bus_oe}, 32'd0);
        check("R9 overrun", {31'd0, overrun}, 32'd0);
        check("R9 we", {31'd0, reg_we}, 32'd0);
        check("R9 re", {31'd0, reg_re}, 32'd0);
    endtask

    task automatic t_write();
        int w0 = we_cnt;
        in_write = 1'b1;
        phase(32'h1000_0040, 1'b1);
        check("R1 no we after address", we_cnt, w0);
        phase(32'hCAFE_0001, 1'b0);
        check("R1 one we", we_cnt, w0 + 1);
        check("R1 addr", last_waddr, 32'h1000_0040);
        check("R1 data", last_wdata, 32'hCAFE_0001);
        check("R5 oe idle", {31'd0, bus_oe}, 32'd0);
        in_write = 1'b0;
    endtask

    task automatic t_late_capture();
        int w0 = we_cnt;
        in_write = 1'b1;
        @(negedge clk); bus_in = 32'h0000_1111; wr_sel_in = 1'b1;
        @(negedge clk); start_in = 1'b1;
        repeat (3) @(negedge clk); bus_in = 32'h0000_2222;
        repeat (4) @(negedge clk); start_in = 1'b0;
        repeat (6) @(negedge clk);
        phase(32'h0BAD_BEEF, 1'b0);
        check("R2 late addr", last_waddr, 32'h0000_2222);
        check("R2 one we", we_cnt, w0 + 1);
        in_write = 1'b0;
    endtask

    task automatic t_readdress();
        int w0 = we_cnt;
        in_write = 1'b1;
        phase(32'hAAAA_0001, 1'b1);
        phase(32'hBBBB_0002, 1'b1);
        check("R6 no we on re-address", we_cnt, w0);
        phase(32'h1234_5678, 1'b0);
        check("R6 single we", we_cnt, w0 + 1);
        check("R6 second addr", last_waddr, 32'hBBBB_0002);
        check("R6 data", last_wdata, 32'h1234_5678);
        in_write = 1'b0;
    endtask

    task automatic t_read();
        int r0 = re_cnt;
        int w0 = we_cnt;
        phase(32'h0000_0ABC, 1'b0);
        check("R3 one re", re_cnt, r0 + 1);
        check("R3 re addr", last_raddr, 32'h0000_0ABC);
        check("R4 oe high", {31'd0, bus_oe}, 32'd1);
        check("R4 word", bus_out, 32'h0000_0ABC ^ RD_KEY);
        repeat (20) @(negedge clk);
        check("R4 oe held", {31'd0, bus_oe}, 32'd1);
        check("R4 word held", bus_out, 32'h0000_0ABC ^ RD_KEY);
        // Next phase from hold: a write
        @(negedge clk); bus_in = 32'h0000_0100; wr_sel_in = 1'b1;
        @(negedge clk); start_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 oe drops on rise", {31'd0, bus_oe}, 32'd0);
        in_write = 1'b1;
        start_in = 1'b0;
        repeat (6) @(negedge clk);
        phase(32'h0000_0055, 1'b0);
        check("R1 write after read", last_wdata, 32'h0000_0055);
        check("R1 write after read count", we_cnt, w0 + 1);
        in_write = 1'b0;
        // Read from hold into another read
        phase(32'h0000_0077, 1'b0);
        phase(32'h0000_0099, 1'b0);
        check("R3 read from hold", last_raddr, 32'h0000_0099);
        check("R4 word second read", bus_out, 32'h0000_0099 ^ RD_KEY);
    endtask

    task automatic t_overrun();
        int r0 = re_cnt;
        int w0 = we_cnt;
        check("R7 clear before", {31'd0, overrun}, 32'd0);
        @(negedge clk); bus_in = 32'h0000_0F00; wr_sel_in = 1'b0;
        @(negedge clk); start_in = 1'b1;
        repeat (4) @(negedge clk);
        start_in = 1'b0;
        @(negedge clk);
        start_in = 1'b1; bus_in = 32'h0000_0E00; wr_sel_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (bus_oe) begin
                n_bad++;
                $display("FAIL R7: bus_oe actual 1 expected 0 during overrun");
            end
        end
        n_cmp++;
        start_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 overrun set", {31'd0, overrun}, 32'd1);
        check("R7 one re", re_cnt, r0 + 1);
        check("R7 oe low", {31'd0, bus_oe}, 32'd0);
        phase(32'h0000_0D0D, 1'b0);
        check("R7 new phase write", we_cnt, w0 + 1);
        check("R7 new phase addr", last_waddr, 32'h0000_0E00);
        phase(32'h0000_0123, 1'b0);
        check("R7 sticky", {31'd0, overrun}, 32'd1);
        do_reset();
        check("R9 overrun cleared", {31'd0, overrun}, 32'd0);
        check("R9 oe cleared", {31'd0, bus_oe}, 32'd0);
    endtask

    task automatic t_strobes();
        check("R8 we width", max_we_run, 1);
        check("R8 re width", max_re_run, 1);
        check("R8 no overlap", both_cnt, 0);
        check("R5 no oe in write", oe_in_write, 0);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_write();
        t_late_capture();
        t_readdress();
        t_read();
        t_overrun();
        t_strobes();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule